// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches the bus cycles of a processor core and raises a break request when a cycle meets a programmed condition. There are two channels, A and B. Each channel compares the bus address against its own address under a bit mask. Each channel also filters on the kind of cycle (instruction fetch or data access), the direction and the access size. Channel B can additionally demand that the data bus equal a compare value under a data mask.

A mode input selects how the channels combine. In independent mode, a hit on either channel breaks. In sequential mode, a hit on A arms the sequence and only a later hit on B breaks. The break request is a single-cycle registered pulse that appears in the clock cycle after the qualifying bus cycle. A companion flag marks the break as pre-execution when the triggering cycle was an instruction fetch. Two sticky status bits record which channel caused activity, and they are cleared by writing zeros.

The configuration is presented on static input ports, which are held stable while the block is in use. A strobe on `ctrl_wr` stands for a write to the mode setting and disarms the sequence.

Top module: `bus_brk_cmp`

## Requirements
- R1: An address bit takes part in a channel's compare only when its mask bit is 0; a mask bit of 1 makes that address bit a don't-care.
- R2: Channel B matches only when the bus data equals `cmp_data_b` on every bit where `data_mask_b` is 0. Channel A ignores the data bus.
- R3: The cycle-kind field of a condition is at bits [5:4], with bit 4 enabling fetch cycles and bit 5 enabling data cycles. The value 00 disables the channel, so it never hits and never arms.
- R4: The direction field is at bits [3:2], with 01 meaning read only, 10 meaning write only, and 00 or 11 meaning either direction. A fetch cycle always counts as a read, so a fetch-only, write-only condition never hits.
- R5: The size field is at bits [1:0], with 00 meaning any size, 01 byte, 10 word and 11 longword. A value other than 00 must equal `bus_size`, which uses the same codes.
- R6: A fetch cycle never hits a channel whose compare address has bit 0 set while mask bit 0 is clear.
- R7: With `mode_seq`=0, a hit on either channel gives `brk_req`=1 for exactly the one clock after the bus cycle.
- R8: With `mode_seq`=1, a hit on A sets `seq_armed`. A B hit while `seq_armed`=1 gives the break. A B hit with `seq_armed`=0 gives no break.
- R9: A sequential break clears `seq_armed`. A `ctrl_wr` pulse also clears it, and this clear takes priority over arming.
- R10: `brk_pre_exec` is 1 together with `brk_req` exactly when the triggering cycle was a fetch.
- R11: `brk_status[0]` is set by any A hit. `brk_status[1]` is set by a B hit that causes a break. A `stat_wr` pulse clears each bit whose `stat_wr_val` bit is 0, and a set in the same cycle wins over the clear.
- R12: A cycle with `bus_valid`=0 causes no hit, no break, no arming and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_seq | input | 1 | 0 selects independent mode, 1 selects sequential mode |
| ctrl_wr | input | 1 | Mode write strobe; clears the armed flag |
| cmp_addr_a | input | AW | Channel A compare address |
| mask_a | input | AW | Channel A address mask (1 = ignore bit) |
| cond_a | input | 6 | Channel A condition {kind, dir, size} |
| cmp_addr_b | input | AW | Channel B compare address |
| mask_b | input | AW | Channel B address mask |
| cmp_data_b | input | DW | Channel B compare data |
| data_mask_b | input | DW | Channel B data mask (1 = ignore bit) |
| cond_b | input | 6 | Channel B condition {kind, dir, size} |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_addr | input | AW | Bus cycle address |
| bus_data | input | DW | Bus cycle data |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write |
| bus_size | input | 2 | 01 byte, 10 word, 11 longword |
| stat_wr | input | 1 | Status write strobe |
| stat_wr_val | input | 2 | Status write value (0 bits clear) |
| brk_req | output | 1 | Break request pulse |
| brk_pre_exec | output | 1 | Break was triggered by a fetch |
| brk_status | output | 2 | Sticky hit status {B, A} |
| seq_armed | output | 1 | Sequential mode armed flag |

## Verification
A fault in one channel's comparator shows up as a wrong `brk_req` or `brk_pre_exec` in the very next clock after the offending bus cycle. A wrong `seq_armed` flag is visible directly at the port one clock after the A hit or the clear. It also turns into a missing or spurious break on the following B cycle. A fault in the sticky status logic persists, so it remains visible until the bits are cleared by writing zeros.

// File: rtl/bkpt_pkg.sv
// Shared encodings for the bus breakpoint comparator.
// Assumes a 6-bit condition word laid out as {kind[1:0], dir[1:0], size[1:0]}.
package bkpt_pkg;
    typedef struct packed {
        logic [1:0] kind;   // bit0: fetch enabled, bit1: data enabled
        logic [1:0] dir;    // 01 read, 10 write, else either
        logic [1:0] size;   // 00 any, 01 byte, 10 word, 11 long
    } bk_cond_t;

    localparam logic [1:0] DIR_RD   = 2'b01;
    localparam logic [1:0] DIR_WR   = 2'b10;
    localparam logic [1:0] SIZE_ANY = 2'b00;
endpackage

// File: rtl/bk_chan_cmp.sv
// One breakpoint channel: purely combinational match of a bus cycle against
// a programmed address/mask, optional data/mask and cycle condition.
// Assumes the bus fields are valid only while bus_valid is high.
module bk_chan_cmp #(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter bit HAS_DATA = 1'b0
) (
    input  logic [AW-1:0] cmp_addr,
    input  logic [AW-1:0] addr_mask,
    input  logic [DW-1:0] cmp_data,
    input  logic [DW-1:0] data_mask,
    input  logic [5:0]    cond,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          bus_fetch,
    input  logic          bus_write,
    input  logic [1:0]    bus_size,
    output logic          hit
);
    import bkpt_pkg::*;

    bk_cond_t c;
    logic kind_ok, dir_ok, size_ok, addr_ok, data_ok, odd_fetch, eff_write;

    assign c = bk_cond_t'(cond);

    // Evaluate each part of the condition and combine them into the hit.
    always_comb begin
        eff_write = bus_write & ~bus_fetch;
        kind_ok   = bus_fetch ? c.kind[0] : c.kind[1];
        if (c.dir == DIR_RD)      dir_ok = ~eff_write;
        else if (c.dir == DIR_WR) dir_ok = eff_write;
        else                      dir_ok = 1'b1;
        size_ok   = (c.size == SIZE_ANY) || (c.size == bus_size);
        addr_ok   = ((bus_addr ^ cmp_addr) & ~addr_mask) == '0;
        data_ok   = HAS_DATA ? (((bus_data ^ cmp_data) & ~data_mask) == '0) : 1'b1;
        odd_fetch = bus_fetch & cmp_addr[0] & ~addr_mask[0];
        hit = bus_valid & kind_ok & dir_ok & size_ok & addr_ok & data_ok & ~odd_fetch;
    end
endmodule

// File: rtl/bk_seq_ctrl.sv
// Combines the two channel hits according to the mode. It holds the
// sequence armed flag, registers the break pulse and keeps sticky status.
// Assumes the hits are already qualified by the bus strobe.
module bk_seq_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_seq,
    input  logic       ctrl_wr,
    input  logic       hit_a,
    input  logic       hit_b,
    input  logic       bus_fetch,
    input  logic       stat_wr,
    input  logic [1:0] stat_wr_val,
    output logic       brk_req,
    output logic       brk_pre_exec,
    output logic [1:0] brk_status,
    output logic       seq_armed
);
    logic fire_b, fire, armed_nxt;
    logic [1:0] status_nxt;

    // Decide whether this cycle breaks and what the next armed/status state is.
    always_comb begin
        fire_b = mode_seq ? (hit_b & seq_armed) : hit_b;
        fire   = mode_seq ? fire_b : (hit_a | hit_b);
        if (ctrl_wr)                armed_nxt = 1'b0;
        else if (mode_seq && fire)  armed_nxt = 1'b0;
        else if (mode_seq && hit_a) armed_nxt = 1'b1;
        else                        armed_nxt = seq_armed;
        status_nxt = (stat_wr ? (brk_status & stat_wr_val) : brk_status)
                     | {fire_b, hit_a};
    end

    // Register the break pulse, its fetch flag, the armed flag and the status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_req      <= 1'b0;
            brk_pre_exec <= 1'b0;
            seq_armed    <= 1'b0;
            brk_status   <= 2'b00;
        end else begin
            brk_req      <= fire;
            brk_pre_exec <= fire & bus_fetch;
            seq_armed    <= armed_nxt;
            brk_status   <= status_nxt;
        end
    end
endmodule

// File: rtl/bus_brk_cmp.sv
// Top of the two-channel bus breakpoint comparator. It holds two channel
// comparators (B with a data compare) feeding the mode and sequence control.
// Assumes the configuration inputs are static while the bus is monitored.
module bus_brk_cmp #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_seq,
    input  logic          ctrl_wr,
    input  logic [AW-1:0] cmp_addr_a,
    input  logic [AW-1:0] mask_a,
    input  logic [5:0]    cond_a,
    input  logic [AW-1:0] cmp_addr_b,
    input  logic [AW-1:0] mask_b,
    input  logic [DW-1:0] cmp_data_b,
    input  logic [DW-1:0] data_mask_b,
    input  logic [5:0]    cond_b,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          bus_fetch,
    input  logic          bus_write,
    input  logic [1:0]    bus_size,
    input  logic          stat_wr,
    input  logic [1:0]    stat_wr_val,
    output logic          brk_req,
    output logic          brk_pre_exec,
    output logic [1:0]    brk_status,
    output logic          seq_armed
);
    logic hit_a, hit_b;

    bk_chan_cmp #(.AW(AW), .DW(DW), .HAS_DATA(1'b0)) u_chan_a (
        .cmp_addr(cmp_addr_a), .addr_mask(mask_a),
        .cmp_data('0), .data_mask('1), .cond(cond_a),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_size(bus_size),
        .hit(hit_a)
    );

    bk_chan_cmp #(.AW(AW), .DW(DW), .HAS_DATA(1'b1)) u_chan_b (
        .cmp_addr(cmp_addr_b), .addr_mask(mask_b),
        .cmp_data(cmp_data_b), .data_mask(data_mask_b), .cond(cond_b),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_size(bus_size),
        .hit(hit_b)
    );

    bk_seq_ctrl u_seq (
        .clk(clk), .rst_n(rst_n), .mode_seq(mode_seq), .ctrl_wr(ctrl_wr),
        .hit_a(hit_a), .hit_b(hit_b), .bus_fetch(bus_fetch),
        .stat_wr(stat_wr), .stat_wr_val(stat_wr_val),
        .brk_req(brk_req), .brk_pre_exec(brk_pre_exec),
        .brk_status(brk_status), .seq_armed(seq_armed)
    );
endmodule

// File: rtl/bus_brk_cmp_chk.sv
// Property checker for bus_brk_cmp; attached by bind below.
// Assumes it sees the top's ports plus the two internal channel hits.
module bus_brk_cmp_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_seq,
    input logic          ctrl_wr,
    input logic [AW-1:0] cmp_addr_a,
    input logic [AW-1:0] mask_a,
    input logic [5:0]    cond_a,
    input logic [5:0]    cond_b,
    input logic          bus_valid,
    input logic          bus_fetch,
    input logic          hit_a,
    input logic          hit_b,
    input logic          brk_req,
    input logic          brk_pre_exec,
    input logic [1:0]    brk_status,
    input logic          seq_armed
);
    p_disabled_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_a[5:4] == 2'b00) |-> !hit_a);
    p_disabled_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_b[5:4] == 2'b00) |-> !hit_b);
    p_fetch_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fetch && cond_a[5:4] == 2'b01 && cond_a[3:2] == 2'b10) |-> !hit_a);
    p_odd_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fetch && cmp_addr_a[0] && !mask_a[0]) |-> !hit_a);
    p_resp_follows_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(bus_valid));
    p_seq_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_seq && hit_b && !seq_armed) |=> !brk_req);
    p_fire_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_seq && hit_b && seq_armed) |=> !seq_armed);
    p_ctrl_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !seq_armed);
    p_pre_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pre_exec |-> brk_req);
    p_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (brk_status != 2'b00));
    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (!hit_a && !hit_b));
endmodule

bind bus_brk_cmp bus_brk_cmp_chk #(.AW(AW)) u_chk (.*);

// File: tb/bus_brk_cmp_bench.sv
module bus_brk_cmp_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_seq = 1'b0, ctrl_wr = 1'b0;
    logic [31:0] cmp_addr_a = '0, mask_a = '0, cmp_addr_b = '0, mask_b = '0;
    logic [31:0] cmp_data_b = '0, data_mask_b = '0;
    logic [5:0]  cond_a = '0, cond_b = '0;
    logic        bus_valid = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0;
    logic [31:0] bus_addr = '0, bus_data = '0;
    logic [1:0]  bus_size = 2'b11;
    logic        stat_wr = 1'b0;
    logic [1:0]  stat_wr_val = 2'b11;
    logic        brk_req, brk_pre_exec, seq_armed;
    logic [1:0]  brk_status;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bus_brk_cmp u_bus_brk_cmp (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected hit computed from the requirement text (R1..R6).
    function automatic bit mdl_hit(input logic [31:0] ca, input logic [31:0] am,
                                   input logic [31:0] cd, input logic [31:0] dm,
                                   input logic [5:0] cond, input bit hasd,
                                   input bit f, input bit w, input logic [1:0] sz,
                                   input logic [31:0] a, input logic [31:0] d);
        bit rd_like, ok;
        rd_like = f || !w;
        ok = f ? cond[4] : cond[5];
        if (cond[3:2] == 2'b01) ok = ok && rd_like;
        if (cond[3:2] == 2'b10) ok = ok && !rd_like;
        if (cond[1:0] != 2'b00) ok = ok && (cond[1:0] == sz);
        for (int i = 0; i < 32; i++)
            if (!am[i] && a[i] != ca[i]) ok = 1'b0;
        if (hasd)
            for (int i = 0; i < 32; i++)
                if (!dm[i] && d[i] != cd[i]) ok = 1'b0;
        if (f && ca[0] && !am[0]) ok = 1'b0;
        return ok;
    endfunction

    // One bus cycle; results are sampled one clock later, at the falling edge.
    task automatic bus_cyc(input bit f, input bit w, input logic [1:0] sz,
                           input logic [31:0] a, input logic [31:0] d, input bit v = 1'b1);
        bus_valid = v; bus_fetch = f; bus_write = w; bus_size = sz;
        bus_addr = a; bus_data = d;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic pulse_ctrl();
        ctrl_wr = 1'b1; @(posedge clk); @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic write_stat(input logic [1:0] v);
        stat_wr = 1'b1; stat_wr_val = v; @(posedge clk); @(negedge clk); stat_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("reset brk_req", {31'b0, brk_req}, 32'd0);
        chk("reset status", {30'b0, brk_status}, 32'd0);
        chk("reset armed", {31'b0, seq_armed}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep of channel A in independent mode (R1, R3, R4, R5, R7, R10).
        cmp_addr_a = 32'h0003_7226; mask_a = 32'h0000_00F0; cond_b = 6'h00;
        for (int k = 0; k < 4; k++)
        for (int dr = 0; dr < 4; dr++)
        for (int s = 0; s < 4; s++)
        for (int f = 0; f < 2; f++)
        for (int w = 0; w < 2; w++)
        for (int bs = 1; bs < 4; bs++)
        for (int av = 0; av < 3; av++) begin
            logic [31:0] a;
            bit e;
            a = (av == 0) ? cmp_addr_a : (av == 1) ? (cmp_addr_a ^ 32'h30) : (cmp_addr_a ^ 32'h4);
            cond_a = {k[1:0], dr[1:0], s[1:0]};
            e = mdl_hit(cmp_addr_a, mask_a, '0, '1, cond_a, 1'b0, f[0], w[0], bs[1:0], a, 32'hDEAD_BEEF);
            bus_cyc(f[0], w[0], bs[1:0], a, 32'hDEAD_BEEF);
            chk("R1/R3/R4/R5/R7 chanA brk", {31'b0, brk_req}, {31'b0, e});
            chk("R10 pre_exec", {31'b0, brk_pre_exec}, {31'b0, e && f[0]});
        end

        // R6: odd compare address never hits on fetch, does hit on data access.
        cond_a = 6'b11_00_00; cmp_addr_a = 32'h0003_1415; mask_a = '0;
        bus_cyc(1'b1, 1'b0, 2'b10, 32'h0003_1415, '0);
        chk("R6 odd fetch no hit", {31'b0, brk_req}, 32'd0);
        bus_cyc(1'b0, 1'b0, 2'b10, 32'h0003_1415, '0);
        chk("R6 odd data hits", {31'b0, brk_req}, 32'd1);
        mask_a = 32'h1;
        bus_cyc(1'b1, 1'b0, 2'b10, 32'h0003_1414, '0);
        chk("R6 masked bit0 fetch hits", {31'b0, brk_req}, 32'd1);

        // R12: strobe low with matching fields gives nothing.
        write_stat(2'b00);
        bus_cyc(1'b0, 1'b0, 2'b10, 32'h0003_1414, '0, 1'b0);
        chk("R12 idle no brk", {31'b0, brk_req}, 32'd0);
        chk("R12 idle no status", {30'b0, brk_status}, 32'd0);

        // Sweep of channel B data compare (R2), channel A disabled.
        cond_a = 6'h00; cmp_addr_b = 32'h0003_722E; mask_b = 32'h0000_0F00;
        cmp_data_b = 32'h1234_5678; data_mask_b = 32'h0000_FF00;
        cond_b = 6'b10_00_00;
        for (int dv = 0; dv < 3; dv++)
        for (int av = 0; av < 3; av++)
        for (int w = 0; w < 2; w++)
        for (int f = 0; f < 2; f++) begin
            logic [31:0] a, d;
            bit e;
            a = (av == 0) ? cmp_addr_b : (av == 1) ? (cmp_addr_b ^ 32'h300) : (cmp_addr_b ^ 32'h8);
            d = (dv == 0) ? cmp_data_b : (dv == 1) ? (cmp_data_b ^ 32'h1100) : (cmp_data_b ^ 32'h1);
            e = mdl_hit(cmp_addr_b, mask_b, cmp_data_b, data_mask_b, cond_b, 1'b1, f[0], w[0], 2'b11, a, d);
            bus_cyc(f[0], w[0], 2'b11, a, d);
            chk("R2 chanB data brk", {31'b0, brk_req}, {31'b0, e});
        end
        // R2: channel A ignores data.
        cond_b = 6'h00; cond_a = 6'b10_00_00; cmp_addr_a = 32'h100; mask_a = '0;
        bus_cyc(1'b0, 1'b1, 2'b01, 32'h100, 32'hFFFF_FFFF);
        chk("R2 chanA ignores data", {31'b0, brk_req}, 32'd1);

        // Sequential mode (R8, R9, R11).
        mode_seq = 1'b1; pulse_ctrl(); write_stat(2'b00);
        cond_a = 6'b10_10_00; cmp_addr_a = 32'h0000_0200;
        cond_b = 6'b10_01_00; cmp_addr_b = 32'h0000_0300; mask_b = '0;
        cmp_data_b = '0; data_mask_b = '1;
        bus_cyc(1'b0, 1'b0, 2'b11, 32'h300, '0);
        chk("R8 B alone no brk", {31'b0, brk_req}, 32'd0);
        chk("R8 B alone not armed", {31'b0, seq_armed}, 32'd0);
        bus_cyc(1'b0, 1'b1, 2'b11, 32'h200, '0);
        chk("R8 A no brk", {31'b0, brk_req}, 32'd0);
        chk("R8 A arms", {31'b0, seq_armed}, 32'd1);
        bus_cyc(1'b0, 1'b0, 2'b11, 32'h300, '0);
        chk("R8 B after A brk", {31'b0, brk_req}, 32'd1);
        chk("R9 fire disarms", {31'b0, seq_armed}, 32'd0);
        chk("R11 status both", {30'b0, brk_status}, 32'd3);
        bus_cyc(1'b0, 1'b0, 2'b11, 32'h300, '0);
        chk("R9 second B no brk", {31'b0, brk_req}, 32'd0);
        bus_cyc(1'b0, 1'b1, 2'b11, 32'h200, '0);
        pulse_ctrl();
        chk("R9 ctrl_wr disarms", {31'b0, seq_armed}, 32'd0);
        bus_cyc(1'b0, 1'b0, 2'b11, 32'h300, '0);
        chk("R9 B after clear no brk", {31'b0, brk_req}, 32'd0);
        // R9: clear wins over arming in the same cycle.
        ctrl_wr = 1'b1;
        bus_cyc(1'b0, 1'b1, 2'b11, 32'h200, '0);
        ctrl_wr = 1'b0;
        chk("R9 clear beats arm", {31'b0, seq_armed}, 32'd0);

        // R11: write-0-to-clear, per bit.
        write_stat(2'b10);
        chk("R11 clear A keep B", {30'b0, brk_status}, 32'd2);
        write_stat(2'b00);
        chk("R11 clear all", {30'b0, brk_status}, 32'd0);
        // R11: set wins over clear.
        stat_wr = 1'b1; stat_wr_val = 2'b00;
        bus_cyc(1'b0, 1'b1, 2'b11, 32'h200, '0);
        stat_wr = 1'b0;
        chk("R11 set beats clear", {30'b0, brk_status}, 32'd1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule